// File: doc/BRIEF.md
# UART Rate Generator and Frame Decoder

This block turns the core clock into the two timing strobes that a UART's serial engines run on: a sample tick and a bit tick. The selected clock (either the core clock itself or one in every eight core cycles) is divided by a 16-bit clock divisor to form the sample tick. Every (bit divisor + 1) sample ticks a bit tick is issued, in the same cycle as a sample tick. The serial bit rate is therefore the selected clock rate divided by (clock divisor × (bit divisor + 1)).

The block also holds the mode register and decodes it into the frame shape used by the transmitter, the receiver and the receive timeout logic. The decoded values are the count of data bits, whether parity is used and its sense, and one or two stop bits. It also gives the total length of a character in bit times. A divisor write with a value that would produce an unusable rate is dropped without trace. An accepted write to any of the three registers restarts both dividers, so that a new rate starts from a clean phase.

Top module: `uart_rate_gen`

## Requirements
- R1: Mode bit 0 at 1 makes the dividers advance once every 8 core cycles; at 0 they advance every core cycle.
- R2: After a restart, sample_tick is first high in core cycle C-1 (raw clock) or 8C-1 (prescaled), counting the first cycle after the restart as 0, where C is the clock divisor, and then repeats every C (or 8C) cycles. With C = 1 and the raw clock, it is high in every cycle.
- R3: bit_tick is high only together with sample_tick, on every (B+1)-th sample tick after a restart, where B is the bit divisor.
- R4: A clock divisor write of 0 changes neither the stored divisor nor the tick phase. Any nonzero 16-bit value is stored.
- R5: A bit divisor write whose low 8 bits are below 4 is ignored. Otherwise the low 8 bits are stored.
- R6: After reset the clock divisor is 651, the bit divisor is 15 and the mode register is 0.
- R7: Mode bits 2:1 give the data length: value 3 gives 6 bits, value 2 gives 7 bits, and any other value gives 8 bits.
- R8: Mode bits 5:3 give the parity: value 0 gives even parity, value 1 gives odd parity, and any other value gives no parity (parity_en = 0).
- R9: Mode bits 7:6 at value 3 give one stop bit (two_stop = 0). Any other value gives two stop bits.
- R10: char_bits equals 1 + data bits + parity bit (if enabled) + stop bits.
- R11: A mode write, or an accepted divisor write, restarts both dividers at the clock edge that takes the write. This also holds when that cycle carries a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_mode | input | 1 | Write strobe for the mode register (bits 7:0 of wr_data) |
| wr_clk_div | input | 1 | Write strobe for the clock divisor |
| wr_bit_div | input | 1 | Write strobe for the bit divisor (bits 7:0 of wr_data) |
| wr_data | input | 16 | Write data |
| sample_tick | output | 1 | One-cycle sample enable |
| bit_tick | output | 1 | One-cycle bit enable |
| mode_reg | output | 8 | Stored mode register |
| clk_div | output | 16 | Stored clock divisor |
| bit_div | output | 8 | Stored bit divisor |
| data_bits | output | 4 | Decoded data bits per character (6, 7 or 8) |
| parity_en | output | 1 | Parity bit present |
| parity_odd | output | 1 | Parity is odd when enabled |
| two_stop | output | 1 | Two stop bits |
| char_bits | output | 4 | Character length in bit times |

## Verification
The two functions that can fall in one cycle are a divisor write and the divider's own wrap, which raises a tick. The bench waits for the cycle in which sample_tick is high and places an accepted clock divisor write on the clock edge that closes that cycle. It then counts the cycles to the next tick: the result must be the full new period, with no carry-over from the old phase. A rejected write, issued one cycle after a restart, is judged the same way. Its next tick must arrive exactly where the old phase puts it.

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
  parameter int CDIV_W   = 16,
  parameter int BDIV_W   = 8,
  parameter int MODE_W   = 8,
  parameter int PRE_W    = 3,
  parameter int CDIV_RST = 651,
  parameter int BDIV_RST = 15,
  parameter int BDIV_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_clk_div,
  input  logic              wr_bit_div,
  input  logic [CDIV_W-1:0] wr_data,
  output logic              sample_tick,
  output logic              bit_tick,
  output logic [MODE_W-1:0] mode_reg,
  output logic [CDIV_W-1:0] clk_div,
  output logic [BDIV_W-1:0] bit_div,
  output logic [3:0]        data_bits,
  output logic              parity_en,
  output logic              parity_odd,
  output logic              two_stop,
  output logic [3:0]        char_bits
);

  logic [PRE_W-1:0]  pre_cnt;
  logic [CDIV_W-1:0] smp_cnt;
  logic [BDIV_W-1:0] bit_cnt;

  logic cdiv_ok, bdiv_ok, reload, pre_en, smp_wrap;

  assign cdiv_ok  = wr_clk_div && (wr_data != '0);
  assign bdiv_ok  = wr_bit_div && (wr_data[BDIV_W-1:0] >= BDIV_W'(BDIV_MIN));
  assign reload   = wr_mode || cdiv_ok || bdiv_ok;
  assign pre_en   = mode_reg[0] ? (&pre_cnt) : 1'b1;
  assign smp_wrap = (smp_cnt == clk_div - CDIV_W'(1));

  assign sample_tick = pre_en && smp_wrap;
  assign bit_tick    = sample_tick && (bit_cnt == bit_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_reg <= '0;
      clk_div  <= CDIV_W'(CDIV_RST);
      bit_div  <= BDIV_W'(BDIV_RST);
    end else begin
      if (wr_mode) mode_reg <= wr_data[MODE_W-1:0];
      if (cdiv_ok) clk_div  <= wr_data;
      if (bdiv_ok) bit_div  <= wr_data[BDIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      smp_cnt <= '0;
      bit_cnt <= '0;
    end else if (reload) begin
      pre_cnt <= '0;
      smp_cnt <= '0;
      bit_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
      if (pre_en) smp_cnt <= smp_wrap ? '0 : smp_cnt + CDIV_W'(1);
      if (sample_tick) bit_cnt <= bit_tick ? '0 : bit_cnt + BDIV_W'(1);
    end
  end

  always_comb begin
    unique case (mode_reg[2:1])
      2'd3:    data_bits = 4'd6;
      2'd2:    data_bits = 4'd7;
      default: data_bits = 4'd8;
    endcase
  end

  assign parity_en  = (mode_reg[5:3] == 3'd0) || (mode_reg[5:3] == 3'd1);
  assign parity_odd = (mode_reg[5:3] == 3'd1);
  assign two_stop   = (mode_reg[7:6] != 2'd3);
  assign char_bits  = 4'd1 + data_bits + {3'd0, parity_en} + (two_stop ? 4'd2 : 4'd1);

endmodule

module uart_rate_gen_chk #(
  parameter int CDIV_W = 16,
  parameter int BDIV_W = 8,
  parameter int MODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_mode,
  input logic              wr_clk_div,
  input logic              wr_bit_div,
  input logic [CDIV_W-1:0] wr_data,
  input logic              sample_tick,
  input logic              bit_tick,
  input logic [MODE_W-1:0] mode_reg,
  input logic [CDIV_W-1:0] clk_div,
  input logic [BDIV_W-1:0] bit_div
);

  a_r1_prescale_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_reg[0] && sample_tick && !wr_mode) |=> !sample_tick);

  a_r2_unit_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_reg[0] && clk_div == CDIV_W'(1)) |-> sample_tick);

  a_r3_bit_in_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  a_r4_zero_cdiv_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clk_div && wr_data == '0) |=> $stable(clk_div));

  a_r5_small_bdiv_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bit_div && wr_data[BDIV_W-1:0] < BDIV_W'(4)) |=> $stable(bit_div));

endmodule

bind uart_rate_gen uart_rate_gen_chk u_chk (.*);

// File: tb/tb_uart_rate_gen.sv
module tb_uart_rate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 240;

  typedef struct packed {
    logic [7:0]  mode;
    logic [15:0] cd;
    logic [7:0]  bd;
    logic [15:0] n_smp;
    logic [15:0] n_bit;
    logic [3:0]  dbits;
    logic        pen;
    logic        podd;
    logic        stop2;
    logic [3:0]  cbits;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 16'd3, 8'd4, 16'd80,  16'd16, 4'd8, 1'b1, 1'b0, 1'b1, 4'd12},
    '{8'hC6, 16'd2, 8'd5, 16'd120, 16'd20, 4'd6, 1'b1, 1'b0, 1'b0, 4'd9},
    '{8'hCC, 16'd5, 8'd7, 16'd48,  16'd6,  4'd7, 1'b1, 1'b1, 1'b0, 4'd10},
    '{8'h21, 16'd1, 8'd4, 16'd30,  16'd6,  4'd8, 1'b0, 1'b0, 1'b1, 4'd11},
    '{8'h11, 16'd3, 8'd9, 16'd10,  16'd1,  4'd8, 1'b0, 1'b0, 1'b1, 4'd11},
    '{8'hC2, 16'd1, 8'd4, 16'd240, 16'd48, 4'd8, 1'b1, 1'b0, 1'b0, 4'd11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_mode = 1'b0, wr_clk_div = 1'b0, wr_bit_div = 1'b0;
  logic [15:0] wr_data = '0;
  logic sample_tick, bit_tick, parity_en, parity_odd, two_stop;
  logic [7:0] mode_reg, bit_div;
  logic [15:0] clk_div;
  logic [3:0] data_bits, char_bits;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wr_clk_div(wr_clk_div),
    .wr_bit_div(wr_bit_div), .wr_data(wr_data), .sample_tick(sample_tick),
    .bit_tick(bit_tick), .mode_reg(mode_reg), .clk_div(clk_div),
    .bit_div(bit_div), .data_bits(data_bits), .parity_en(parity_en),
    .parity_odd(parity_odd), .two_stop(two_stop), .char_bits(char_bits)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_now(input int sel, input logic [15:0] d);
    wr_data = d;
    wr_mode = (sel == 0);
    wr_clk_div = (sel == 1);
    wr_bit_div = (sel == 2);
    @(posedge clk);
    #1;
    wr_mode = 1'b0; wr_clk_div = 1'b0; wr_bit_div = 1'b0;
  endtask

  task automatic wr(input int sel, input logic [15:0] d);
    @(negedge clk);
    wr_now(sel, d);
  endtask

  task automatic count_ticks(output int ns, output int nb);
    ns = 0; nb = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (sample_tick) ns++;
      if (bit_tick) nb++;
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    for (int i = 0; i < 100000; i++) begin
      @(negedge clk);
      if (sample_tick) break;
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int ns, nb, gap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R6 clk_div reset", int'(clk_div), 651);
    check("R6 bit_div reset", int'(bit_div), 15);
    check("R6 mode reset", int'(mode_reg), 0);
    check("R10 reset char_bits", int'(char_bits), 12);

    for (int v = 0; v < NV; v++) begin
      wr(0, {8'h00, VEC[v].mode});
      wr(1, VEC[v].cd);
      wr(2, {8'h00, VEC[v].bd});
      count_ticks(ns, nb);
      check("R1 R2 sample tick count", ns, int'(VEC[v].n_smp));
      check("R3 bit tick count", nb, int'(VEC[v].n_bit));
      check("R7 data bits", int'(data_bits), int'(VEC[v].dbits));
      check("R8 parity enable", int'(parity_en), int'(VEC[v].pen));
      if (VEC[v].pen) check("R8 parity odd", int'(parity_odd), int'(VEC[v].podd));
      check("R9 two stop", int'(two_stop), int'(VEC[v].stop2));
      check("R10 char bits", int'(char_bits), int'(VEC[v].cbits));
    end

    // Mode 0xC2 is in force: raw clock, bit divisor 4.
    wr(1, 16'd4);
    wr(1, 16'd0);
    wait_tick(gap);
    check("R4 zero write keeps phase", gap, 2);
    check("R4 zero write keeps value", int'(clk_div), 4);

    wr(2, 16'd3);
    check("R5 small bit divisor ignored", int'(bit_div), 4);
    wr(2, 16'h0105);
    check("R5 low byte stored", int'(bit_div), 5);

    wait_tick(gap);
    wr_now(1, 16'd5);
    wait_tick(gap);
    check("R11 write on tick cycle restarts", gap, 4);

    repeat (2) @(negedge clk);
    wr_now(0, 16'h0000);
    wait_tick(gap);
    check("R11 mode write restarts", gap, 4);

    wr(0, 16'h0001);
    wait_tick(gap);
    check("R1 R2 prescaled first tick", gap, 39);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule